// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block turns parallel words into asynchronous serial frames on a single transmit line. Each frame has one start bit (low), then 7, 8 or 9 data bits sent least significant bit first, then one or two stop bits (high). The word length, the parity scheme and the stop-bit count are all set at run time. When parity is on, the computed parity bit takes the place of the highest data bit of the selected length, so parity does not make the frame longer.

Words come in through a valid/ready handshake. The bit timing comes from an external baud tick that pulses once per bit time. A block enable gates everything. Dropping the enable stops the line at once, abandons the frame in progress and clears all flags. A separate transmit enable stops new words from being accepted. A low pulse on the transmit enable queues one idle character, which is a whole frame time of high line, to go out after the current word. The word-length and parity settings are captured only while the block enable is low.

Top module: `uart_frame_tx`

## Requirements
- R1: The word-length code selects the number of data bits: 2'b00 gives 8, 2'b01 gives 9, 2'b10 gives 7, and the reserved 2'b11 gives 8. A frame is a start bit of 0, then the data bits with in_data[0] first, then the stop bits.
- R2: With par_en set, the last data position (bit index n-1 for n data bits) carries parity over in_data bits 0..n-2 instead of in_data[n-1]. With par_odd at 0 the count of ones in those n bits is even. With par_odd at 1 it is odd.
- R3: two_stop at 0 gives one stop bit and at 1 gives two. It is sampled when the frame starts.
- R4: Word length, parity enable and parity select are captured only while blk_en is low. Changing those inputs while blk_en is high has no effect on frames sent before the next disable.
- R5: While blk_en is low, tx_line is 1 and busy, tx_done and in_ready are 0, all in the same cycle blk_en drops. A frame cut off this way is not resumed. The captured settings survive the disable.
- R6: A 0-to-1 transition of tx_en while blk_en is high queues an idle frame. The idle frame is all ones and lasts 1 + data bits + stop bits bit times. It is sent after the current frame. No word is accepted until it has been sent.
- R7: in_ready is high only when blk_en and tx_en are high, no frame is being sent and no idle frame is queued. In the cycle after a word is accepted, busy is 1 and tx_line shows the start bit.
- R8: Each bit, including the first, ends at the rising clock edge where baud_tick is high. The frame ends at the tick that closes its last bit. Whenever busy is 0, tx_line is 1.
- R9: tx_done goes high in the cycle after the last bit of a frame ends. It goes low when a new frame starts, and it is never high together with busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| blk_en | input | 1 | Block enable; low clears and stops, and allows configuration capture |
| tx_en | input | 1 | Transmit enable; a low pulse queues an idle frame |
| par_en | input | 1 | Parity on |
| par_odd | input | 1 | 0 even parity, 1 odd parity |
| wlen_code | input | 2 | Word-length code |
| two_stop | input | 1 | 0 one stop bit, 1 two stop bits |
| baud_tick | input | 1 | One-cycle pulse per bit time |
| in_valid | input | 1 | Word offered |
| in_data | input | 9 | Word to send, bit 0 first |
| in_ready | output | 1 | Word accepted when in_valid is also high |
| tx_line | output | 1 | Serial output, idles high |
| busy | output | 1 | A frame (data or idle) is on the line |
| tx_done | output | 1 | Last frame finished, nothing started since |

## Verification
A word accepted at a clock edge shows its start bit, with busy high, from the next cycle on. So the bench checks the start bit and busy at the first falling edge after acceptance. Every later bit is sampled at the falling edge just before a tick edge, because that value is the bit the tick closes. tx_done and the return of in_ready are checked one falling edge after the tick that closes the last bit. The effect of dropping blk_en is combinational, so it is checked one time step after the drop, in the same cycle. The queued idle frame begins one edge after the data frame ends, and its length is checked by counting ticks while busy stays high.

// File: rtl/uft_pkg.sv
// Shared sizes and types for the UART frame transmitter.
// Assumes at most DATA_MAX data bits and STOP_MAX stop bits per frame.
package uft_pkg;
    parameter int DATA_MAX = 9;
    parameter int STOP_MAX = 2;
    localparam int FRAME_W = 1 + DATA_MAX + STOP_MAX;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } tx_state_t;

    typedef struct packed {
        logic [1:0] wlen;
        logic       par_en;
        logic       par_odd;
    } tx_cfg_t;
endpackage

// File: rtl/uft_cfg.sv
// Configuration capture: follows the word-length and parity inputs while
// the block is disabled and holds them while it is enabled.
// Assumes software only reconfigures with the block disabled.
module uft_cfg
    import uft_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    blk_en,
    input  tx_cfg_t cfg_in,
    output tx_cfg_t cfg_q
);
    // Load settings only while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (!blk_en) begin
            cfg_q <= cfg_in;
        end
    end
endmodule

// File: rtl/uft_framer.sv
// Frame builder: lays out start bit, data bits (parity in the top data
// position when enabled) and stop bits as a vector sent bit 0 first, and
// gives the total number of bit times. Purely combinational.
// Assumes unused positions above the frame are ones.
module uft_framer
    import uft_pkg::*;
(
    input  tx_cfg_t              cfg,
    input  logic                 two_stop,
    input  logic [DATA_MAX-1:0]  data,
    output logic [FRAME_W-1:0]   frame,
    output logic [CNT_W-1:0]     nbits
);
    int   dbits;
    logic par_acc;

    // Decode word length, fold parity over the lower bits and place fields.
    always_comb begin
        case (cfg.wlen)
            2'b01:   dbits = DATA_MAX;
            2'b10:   dbits = DATA_MAX - 2;
            default: dbits = DATA_MAX - 1;
        endcase
        par_acc  = cfg.par_odd;
        frame    = '1;
        frame[0] = 1'b0;
        for (int i = 0; i < DATA_MAX; i++) begin
            if (i < dbits - 1) begin
                frame[i+1] = data[i];
                par_acc    = par_acc ^ data[i];
            end else if (i == dbits - 1) begin
                frame[i+1] = cfg.par_en ? par_acc : data[i];
            end
        end
        nbits = CNT_W'(1 + dbits + (two_stop ? STOP_MAX : 1));
    end
endmodule

// File: rtl/uft_seq.sv
// Bit sequencer: accepts a word or starts a queued idle frame, shifts one
// bit out per baud tick, and keeps the busy, done and idle-request state.
// Assumes baud_tick is a single-cycle pulse; ticks while idle are ignored.
module uft_seq
    import uft_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               blk_en,
    input  logic               tx_en,
    input  logic               baud_tick,
    input  logic               in_valid,
    input  logic [FRAME_W-1:0] frame,
    input  logic [CNT_W-1:0]   nbits,
    output logic               in_ready,
    output logic               tx_line,
    output logic               busy,
    output logic               tx_done
);
    tx_state_t          state;
    logic [FRAME_W-1:0] shreg;
    logic [CNT_W-1:0]   cnt;
    logic               done_q;
    logic               idle_req;
    logic               te_q;

    assign in_ready = blk_en && tx_en && (state == ST_IDLE) && !idle_req;
    assign busy     = blk_en && (state == ST_SEND);
    assign tx_line  = busy ? shreg[0] : 1'b1;
    assign tx_done  = blk_en && done_q;

    // Remember the previous transmit enable to spot its rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) te_q <= 1'b0;
        else        te_q <= tx_en;
    end

    // Frame sequencing, idle-frame queueing and completion flag.
    always_ff @(posedge clk) begin
        if (!rst_n || !blk_en) begin
            state    <= ST_IDLE;
            shreg    <= '1;
            cnt      <= '0;
            done_q   <= 1'b0;
            idle_req <= 1'b0;
        end else begin
            if (tx_en && !te_q) idle_req <= 1'b1;
            case (state)
                ST_IDLE: begin
                    if (idle_req && tx_en) begin
                        shreg    <= '1;
                        cnt      <= nbits;
                        state    <= ST_SEND;
                        idle_req <= 1'b0;
                        done_q   <= 1'b0;
                    end else if (in_valid && in_ready) begin
                        shreg  <= frame;
                        cnt    <= nbits;
                        state  <= ST_SEND;
                        done_q <= 1'b0;
                    end
                end
                ST_SEND: begin
                    if (baud_tick) begin
                        if (cnt == CNT_W'(1)) begin
                            state  <= ST_IDLE;
                            shreg  <= '1;
                            done_q <= 1'b1;
                        end else begin
                            shreg <= {1'b1, shreg[FRAME_W-1:1]};
                            cnt   <= cnt - CNT_W'(1);
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/uart_frame_tx.sv
// Top of the configurable UART frame transmitter: captures settings, builds
// the frame for the offered word and sequences it onto tx_line.
// Assumes an external baud tick at one pulse per bit time.
module uart_frame_tx
    import uft_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                blk_en,
    input  logic                tx_en,
    input  logic                par_en,
    input  logic                par_odd,
    input  logic [1:0]          wlen_code,
    input  logic                two_stop,
    input  logic                baud_tick,
    input  logic                in_valid,
    input  logic [DATA_MAX-1:0] in_data,
    output logic                in_ready,
    output logic                tx_line,
    output logic                busy,
    output logic                tx_done
);
    tx_cfg_t            cfg_in;
    tx_cfg_t            cfg_q;
    logic [FRAME_W-1:0] frame;
    logic [CNT_W-1:0]   nbits;

    assign cfg_in = '{wlen: wlen_code, par_en: par_en, par_odd: par_odd};

    uft_cfg u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .blk_en (blk_en),
        .cfg_in (cfg_in),
        .cfg_q  (cfg_q)
    );

    uft_framer u_framer (
        .cfg      (cfg_q),
        .two_stop (two_stop),
        .data     (in_data),
        .frame    (frame),
        .nbits    (nbits)
    );

    uft_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .blk_en    (blk_en),
        .tx_en     (tx_en),
        .baud_tick (baud_tick),
        .in_valid  (in_valid),
        .frame     (frame),
        .nbits     (nbits),
        .in_ready  (in_ready),
        .tx_line   (tx_line),
        .busy      (busy),
        .tx_done   (tx_done)
    );
endmodule

// File: rtl/uft_checker.sv
// Protocol checker for the UART frame transmitter, bound to the top.
// Assumes synchronous active-low reset; all properties are off in reset.
module uft_checker
    import uft_pkg::*;
(
    input logic    clk,
    input logic    rst_n,
    input logic    blk_en,
    input logic    baud_tick,
    input logic    in_valid,
    input logic    in_ready,
    input logic    tx_line,
    input logic    busy,
    input logic    tx_done,
    input tx_cfg_t cfg_q
);
    logic armed;

    // Mark cycles that have a post-reset cycle behind them.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    assert_idle_line_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> tx_line);

    assert_bit_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !baud_tick) |=> (!blk_en || $stable(tx_line)));

    assert_disable_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !blk_en |-> (tx_line && !busy && !tx_done && !in_ready));

    assert_accept_starts_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (!blk_en || (busy && !tx_line)));

    assert_ready_when_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !busy);

    assert_done_not_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> !busy);

    assert_cfg_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && blk_en && $past(blk_en)) |-> $stable(cfg_q));
endmodule

bind uart_frame_tx uft_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .blk_en    (blk_en),
    .baud_tick (baud_tick),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .tx_line   (tx_line),
    .busy      (busy),
    .tx_done   (tx_done),
    .cfg_q     (cfg_q)
);

// File: tb/uart_frame_tx_tb.sv
`timescale 1ns/1ps
module uart_frame_tx_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       blk_en = 1'b0;
    logic       tx_en = 1'b0;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic [1:0] wlen_code = 2'b00;
    logic       two_stop = 1'b0;
    logic       baud_tick = 1'b0;
    logic       in_valid = 1'b0;
    logic [8:0] in_data = '0;
    logic       in_ready, tx_line, busy, tx_done;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int tick_div = 0;

    logic [1:0] m_wl = 2'b00;
    logic       m_pe = 1'b0;
    logic       m_po = 1'b0;

    uart_frame_tx u_dut (
        .clk(clk), .rst_n(rst_n), .blk_en(blk_en), .tx_en(tx_en),
        .par_en(par_en), .par_odd(par_odd), .wlen_code(wlen_code),
        .two_stop(two_stop), .baud_tick(baud_tick), .in_valid(in_valid),
        .in_data(in_data), .in_ready(in_ready), .tx_line(tx_line),
        .busy(busy), .tx_done(tx_done)
    );

    always #4 clk = ~clk;

    // Baud tick: one pulse every four clocks.
    always @(posedge clk) begin
        tick_div  <= (tick_div == 3) ? 0 : tick_div + 1;
        baud_tick <= (tick_div == 3);
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            checks = checks + 1;
            errors = errors + 1;
            $display("FAIL watchdog: run did not finish, act=%0d exp<=150000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s at %0t: act=%0d exp=%0d", req, $time, act, exp);
        end
    endtask

    function automatic int data_bits(input logic [1:0] wl);
        if (wl == 2'b01) return 9;
        if (wl == 2'b10) return 7;
        return 8;
    endfunction

    function automatic int exp_len(input logic [1:0] wl, input logic ts);
        return 1 + data_bits(wl) + (ts ? 2 : 1);
    endfunction

    function automatic logic [11:0] exp_frame(input logic [8:0] d, input logic [1:0] wl,
                                              input logic pe, input logic po, input logic ts);
        logic [11:0] f = '1;
        int n = data_bits(wl);
        int ones = 0;
        f[0] = 1'b0;
        for (int i = 0; i < n; i++) begin
            logic b = d[i];
            if (pe && i == n - 1) b = po ? ((ones % 2) == 0) : ((ones % 2) == 1);
            else ones = ones + int'(b);
            f[i+1] = b;
        end
        if (ts) f[n+2] = 1'b1;
        return f;
    endfunction

    task automatic set_cfg(input logic [1:0] wl, input logic pe, input logic po);
        @(negedge clk);
        blk_en = 1'b0;
        wlen_code = wl; par_en = pe; par_odd = po;
        @(negedge clk);
        blk_en = 1'b1;
        m_wl = wl; m_pe = pe; m_po = po;
    endtask

    task automatic wait_ready();
        int guard = 0;
        @(negedge clk);
        while (!in_ready && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        chk(in_ready, "R7 ready", int'(in_ready), 1);
    endtask

    // Sends one word and checks every bit; optionally pulses tx_en low (R6).
    task automatic send_word(input logic [8:0] d, input bit pulse);
        logic [11:0] f = exp_frame(d, m_wl, m_pe, m_po, two_stop);
        int len = exp_len(m_wl, two_stop);
        int idx = 0;
        int k = 0;
        wait_ready();
        in_valid = 1'b1; in_data = d;
        @(negedge clk);
        in_valid = 1'b0;
        chk(busy && !tx_line && !tx_done, "R7 start bit", int'({busy, tx_line, tx_done}), 3'b100);
        while (idx < len && k < 400) begin
            if (pulse && k == 1) tx_en = 1'b0;
            if (pulse && k == 2) tx_en = 1'b1;
            if (baud_tick) begin
                chk(busy && tx_line == f[idx], "R1 R2 R3 frame bit", int'(tx_line), int'(f[idx]));
                idx++;
            end
            k++;
            @(negedge clk);
        end
        chk(!busy && tx_done && tx_line, "R9 done after last stop", int'({busy, tx_done, tx_line}), 3'b011);
    endtask

    // Checks a queued idle frame of len bit times.
    task automatic expect_idle(input int len);
        int guard = 0;
        int cnt = 0;
        while (!busy && guard < 50) begin
            @(negedge clk);
            guard++;
        end
        chk(busy && !in_ready, "R6 idle frame started", int'({busy, in_ready}), 2'b10);
        while (cnt < len && guard < 400) begin
            if (baud_tick) begin
                chk(busy && tx_line, "R6 idle bit high", int'({busy, tx_line}), 2'b11);
                cnt++;
            end
            guard++;
            @(negedge clk);
        end
        chk(!busy && in_ready && tx_done, "R6 idle frame length", int'({busy, in_ready, tx_done}), 3'b011);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(tx_line && !busy && !tx_done && !in_ready, "R8 reset state", int'({tx_line, busy, tx_done, in_ready}), 4'b1000);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tx_line && !busy && !in_ready, "R5 disabled after reset", int'({tx_line, busy, in_ready}), 3'b100);

        // Enable, then raise tx_en: one idle frame (R6).
        set_cfg(2'b00, 1'b0, 1'b0);
        @(negedge clk);
        tx_en = 1'b1;
        expect_idle(exp_len(m_wl, two_stop));

        // Directed word lengths, parity and stop bits (R1, R2, R3).
        send_word(9'h0A5, 1'b0);
        set_cfg(2'b10, 1'b1, 1'b0);
        send_word(9'h07F, 1'b0);
        set_cfg(2'b01, 1'b1, 1'b1);
        two_stop = 1'b1;
        send_word(9'h123, 1'b0);
        set_cfg(2'b11, 1'b0, 1'b0);
        two_stop = 1'b0;
        send_word(9'h1FF, 1'b0);

        // R4: setting changes while enabled are ignored.
        wlen_code = 2'b01; par_en = 1'b1;
        send_word(9'h155, 1'b0);
        set_cfg(2'b01, 1'b1, 1'b0);
        send_word(9'h155, 1'b0);

        // R6: low pulse on tx_en during a word queues an idle frame after it.
        send_word(9'h0C3, 1'b1);
        expect_idle(exp_len(m_wl, two_stop));

        // R5: disable mid-frame.
        wait_ready();
        in_valid = 1'b1; in_data = 9'h0F0;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (5) @(negedge clk);
        blk_en = 1'b0;
        #1;
        chk(tx_line && !busy && !tx_done && !in_ready, "R5 disable immediate", int'({tx_line, busy, tx_done, in_ready}), 4'b1000);
        @(negedge clk);
        chk(tx_line && !busy && !tx_done, "R5 disable held", int'({tx_line, busy, tx_done}), 3'b100);
        blk_en = 1'b1;
        @(negedge clk);
        chk(!busy && in_ready && !tx_done, "R5 re-enable clean", int'({busy, in_ready, tx_done}), 3'b010);
        send_word(9'h0A9, 1'b0);

        // Random configurations and data.
        for (int it = 0; it < 30; it++) begin
            bit p;
            set_cfg(2'($urandom % 4), 1'($urandom % 2), 1'($urandom % 2));
            two_stop = 1'($urandom % 2);
            if ($urandom % 3 == 0) begin
                wlen_code = 2'($urandom % 4);
                par_en = ~par_en;
            end
            p = ($urandom % 4 == 0);
            send_word(9'($urandom % 512), p);
            if (p) expect_idle(exp_len(m_wl, two_stop));
            send_word(9'($urandom % 512), 1'b0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule